// File: doc/BRIEF.md
# Request Intake Front-End with Locked Path Selection

This block sits on the target side of a point-to-point graphics request link. It accepts transaction requests from the bus master and writes them into a small request queue that the target's scheduler drains. Requests can arrive by one of two routes. The first is a pipelined route on the main address/data bus: the master pulls an active-low strobe low and holds it, and the block takes one full-width word on every rising clock edge while the strobe stays low. The second is a sideband route: the words arrive already assembled, each with a valid flag. On this route the block also tracks a synchronisation marker.

A configuration input picks the route. The block captures it on the first clock edge after reset is released and keeps it until the next reset. Traffic on the route that was not picked never reaches the queue and raises a sticky protocol-error flag. The sideband route has two further conditions. It stays deaf until its enable input is set. After a stretch of idle cycles it also needs a fresh synchronisation cycle before it accepts another word. A push that finds the queue full is dropped and raises a sticky overflow flag.

Top module: `req_intake_frontend`

## Requirements
- R1: On the first rising edge after `rst_n` goes high, the block captures `cfg_side_sel` (0 = pipelined route, 1 = sideband route) and shows it on `path_o`. Nothing is enqueued in the cycle that ends at that edge. Later changes of `cfg_side_sel` have no effect until the next reset.
- R2: On the pipelined route, every rising edge that sees `pipe_n` low while the queue is not full pushes the `ad_req` word. `push_o` is high and `push_word` equals `ad_req` in that cycle.
- R3: On the pipelined route, no push happens in a cycle where `pipe_n` is high.
- R4: On the sideband route, a cycle with `sb_valid` high pushes `sb_word` only if `cfg_side_en` is 1 and the route is in sync. Otherwise the word is dropped and no error is raised.
- R5: The sideband route is out of sync in three situations: after reset, while `cfg_side_en` is 0, and after IDLE_LIM consecutive enabled cycles with neither `sb_valid` nor `sb_sync`. A cycle with `sb_sync` high brings it back into sync from the next cycle on.
- R6: On the pipelined route, a cycle with `sb_valid` high and `cfg_side_en` high sets `proto_err`. On the sideband route, a cycle with `pipe_n` low sets `proto_err`. In both cases nothing is pushed, and `proto_err` stays set until reset.
- R7: A push attempt while the queue holds DEPTH entries is dropped. It leaves the contents unchanged and sets `ovf_err`, which stays set until reset.
- R8: The queue is first-in first-out. `q_data` shows the oldest entry. A `q_pop` while the queue is not empty removes that entry. `q_count`, `q_empty` and `q_full` give the current fill level.
- R9: During reset the queue is empty, `q_count` is 0, and `push_o`, `proto_err` and `ovf_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_side_sel | input | 1 | Route select, captured once after reset |
| cfg_side_en | input | 1 | Sideband route enable |
| pipe_n | input | 1 | Active-low pipelined request strobe |
| ad_req | input | DATA_W | Request word on the main bus |
| sb_valid | input | 1 | Sideband word valid |
| sb_word | input | DATA_W | Assembled sideband request word |
| sb_sync | input | 1 | Sideband synchronisation cycle marker |
| q_pop | input | 1 | Remove the oldest queue entry |
| push_o | output | 1 | A word is written into the queue this cycle |
| push_word | output | DATA_W | Word being written |
| q_data | output | DATA_W | Oldest queue entry |
| q_empty | output | 1 | Queue empty |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_count | output | clog2(DEPTH+1) | Number of entries in the queue |
| path_o | output | 1 | Latched route (0 pipelined, 1 sideband) |
| proto_err | output | 1 | Sticky wrong-route traffic flag |
| ovf_err | output | 1 | Sticky dropped-on-full flag |

## Verification
The pipelined route is driven with every 4-bit on/off pattern of the strobe, with pops interleaved. This distinguishes back-to-back enqueue, isolated strobes and gaps, and the same patterns also push the queue into overflow and drain it in order. The sideband route is driven with a synchronisation cycle followed by 0 to 6 idle cycles and then a word, which locates the exact idle count at which sync is lost. Separate runs send valid words before any sync, with the enable low, and across an enable drop. Wrong-route stimulus is applied under both latched routes and after a late change of the route-select input, which shows that the route lock and the error flag act independently.

// File: rtl/req_intake_pkg.sv
package req_intake_pkg;
   typedef enum logic {
      PATH_PIPE = 1'b0,
      PATH_SIDE = 1'b1
   } intake_path_e;
endpackage

// File: rtl/rif_mode_lock.sv
module rif_mode_lock
   import req_intake_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sel,
   output logic         locked,
   output intake_path_e path
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked <= 1'b0;
         path   <= PATH_PIPE;
      end else if (!locked) begin
         locked <= 1'b1;
         path   <= intake_path_e'(sel);
      end
   end

   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> (locked && $stable(path)));  // R1
endmodule

// File: rtl/rif_side_sync.sv
module rif_side_sync #(
   parameter int IDLE_LIM = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic valid,
   input  logic sync,
   output logic synced
);
   localparam int CW = (IDLE_LIM > 2) ? $clog2(IDLE_LIM) : 1;

   generate
      if (IDLE_LIM < 2) begin : g_bad_lim
         $error("rif_side_sync: IDLE_LIM must be at least 2");
      end
   endgenerate

   logic [CW-1:0] idle_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         synced   <= 1'b0;
         idle_cnt <= '0;
      end else if (!en) begin
         synced   <= 1'b0;
         idle_cnt <= '0;
      end else if (sync) begin
         synced   <= 1'b1;
         idle_cnt <= '0;
      end else if (valid) begin
         idle_cnt <= '0;
      end else if (idle_cnt == CW'(IDLE_LIM - 1)) begin
         synced   <= 1'b0;
         idle_cnt <= '0;
      end else begin
         idle_cnt <= idle_cnt + CW'(1);
      end
   end

   AST_SYNC_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(synced) |-> $past(sync && en));  // R5
   AST_DISABLED_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !synced);  // R5
endmodule

// File: rtl/rif_fifo.sv
module rif_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int  PW      = (DEPTH > 2) ? $clog2(DEPTH) : 1;
   localparam int  CW      = $clog2(DEPTH + 1);
   localparam bit  IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rif_fifo: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("rif_fifo: W must be positive");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          do_push, do_pop;

   generate
      if (IS_POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + PW'(1);
         assign rd_nxt = rd_ptr + PW'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      end
   endgenerate

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));  // R7
   AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !(pop && !empty)) |=> (count == $past(count) + CW'(1)));  // R8
   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && pop && !empty) |=> (count == $past(count) - CW'(1)));  // R8
endmodule

// File: rtl/req_intake_frontend.sv
module req_intake_frontend
   import req_intake_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int DEPTH    = 8,
   parameter int IDLE_LIM = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_side_sel,
   input  logic                       cfg_side_en,
   input  logic                       pipe_n,
   input  logic [DATA_W-1:0]          ad_req,
   input  logic                       sb_valid,
   input  logic [DATA_W-1:0]          sb_word,
   input  logic                       sb_sync,
   input  logic                       q_pop,
   output logic                       push_o,
   output logic [DATA_W-1:0]          push_word,
   output logic [DATA_W-1:0]          q_data,
   output logic                       q_empty,
   output logic                       q_full,
   output logic [$clog2(DEPTH+1)-1:0] q_count,
   output logic                       path_o,
   output logic                       proto_err,
   output logic                       ovf_err
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("req_intake_frontend: DATA_W must be positive");
      end
   endgenerate

   logic         locked;
   intake_path_e path_q;
   logic         sb_synced;
   logic         try_pipe, try_side, attempt, stray;

   rif_mode_lock u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (cfg_side_sel),
      .locked (locked),
      .path   (path_q)
   );

   rif_side_sync #(.IDLE_LIM(IDLE_LIM)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cfg_side_en),
      .valid  (sb_valid),
      .sync   (sb_sync),
      .synced (sb_synced)
   );

   assign try_pipe = locked && (path_q == PATH_PIPE) && !pipe_n;
   assign try_side = locked && (path_q == PATH_SIDE) && cfg_side_en && sb_synced && sb_valid;
   assign attempt  = try_pipe || try_side;
   assign stray    = locked && (((path_q == PATH_PIPE) && cfg_side_en && sb_valid) ||
                                ((path_q == PATH_SIDE) && !pipe_n));

   assign push_word = (path_q == PATH_PIPE) ? ad_req : sb_word;
   assign push_o    = attempt && !q_full;
   assign path_o    = path_q;

   rif_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_o),
      .din   (push_word),
      .pop   (q_pop),
      .dout  (q_data),
      .empty (q_empty),
      .full  (q_full),
      .count (q_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         proto_err <= 1'b0;
         ovf_err   <= 1'b0;
      end else begin
         if (stray)             proto_err <= 1'b1;
         if (attempt && q_full) ovf_err   <= 1'b1;
      end
   end

   AST_NO_PUSH_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> !push_o);  // R1
   AST_PIPE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && path_o == 1'b0 && !pipe_n && !q_full) |-> push_o);  // R2
   AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (path_o == 1'b0 && pipe_n) |-> !push_o);  // R3
   AST_SIDE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (push_o && path_o == 1'b1) |-> (cfg_side_en && sb_synced && sb_valid));  // R4
   AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);  // R6
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> ovf_err);  // R7
   AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> !push_o);  // R7
endmodule

// File: tb/tb_req_intake_frontend.sv
`timescale 1ns/1ps
module tb_req_intake_frontend;
   localparam int W = 8;
   localparam int D = 4;
   localparam int L = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_side_sel = 1'b0, cfg_side_en = 1'b0;
   logic pipe_n = 1'b1, sb_valid = 1'b0, sb_sync = 1'b0, q_pop = 1'b0;
   logic [W-1:0] ad_req = '0, sb_word = '0;
   logic push_o, q_empty, q_full, path_o, proto_err, ovf_err;
   logic [W-1:0] push_word, q_data;
   logic [2:0] q_count;

   always #10 clk = ~clk;

   req_intake_frontend #(.DATA_W(W), .DEPTH(D), .IDLE_LIM(L)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_side_sel(cfg_side_sel), .cfg_side_en(cfg_side_en),
      .pipe_n(pipe_n), .ad_req(ad_req), .sb_valid(sb_valid), .sb_word(sb_word),
      .sb_sync(sb_sync), .q_pop(q_pop), .push_o(push_o), .push_word(push_word),
      .q_data(q_data), .q_empty(q_empty), .q_full(q_full), .q_count(q_count),
      .path_o(path_o), .proto_err(proto_err), .ovf_err(ovf_err));

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench model
   logic [W-1:0] mq [D];
   int  mcount;
   bit  m_locked, m_mode, m_synced, m_perr, m_ovf;
   int  m_idle;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      mcount = 0; m_locked = 0; m_mode = 0; m_synced = 0;
      m_perr = 0; m_ovf = 0; m_idle = 0;
   endtask

   // Enter just after a falling edge; leaves just after the next falling edge.
   task automatic cyc(input string tag, input logic pn, input logic [W-1:0] ad,
                      input logic sv, input logic [W-1:0] sw, input logic ss,
                      input logic pp);
      bit att, stray, exp_push;
      string t;
      logic [W-1:0] wexp;
      pipe_n = pn; ad_req = ad; sb_valid = sv; sb_word = sw; sb_sync = ss; q_pop = pp;
      #5;
      att   = m_locked && ((!m_mode && !pn) ||
                           (m_mode && cfg_side_en && m_synced && sv));
      stray = m_locked && ((!m_mode && cfg_side_en && sv) || (m_mode && !pn));
      exp_push = att && (mcount < D);
      wexp = m_mode ? sw : ad;
      t = (att && mcount == D) ? "R7" : tag;
      chk(t, "push_o", int'(push_o), int'(exp_push));
      if (exp_push && push_o) chk(t, "push_word", int'(push_word), int'(wexp));
      chk(t, "q_count", int'(q_count), mcount);
      chk(t, "q_empty", int'(q_empty), int'(mcount == 0));
      chk(t, "q_full", int'(q_full), int'(mcount == D));
      if (mcount > 0) chk("R8", "q_data", int'(q_data), int'(mq[0]));
      chk(t, "proto_err", int'(proto_err), int'(m_perr));
      chk(t, "ovf_err", int'(ovf_err), int'(m_ovf));
      if (m_locked) chk("R1", "path_o", int'(path_o), int'(m_mode));
      @(posedge clk);
      // model update at the edge
      if (stray) m_perr = 1;
      if (att && mcount == D) m_ovf = 1;
      if (pp && mcount > 0) begin
         for (int i = 0; i < D - 1; i++) mq[i] = mq[i+1];
         mcount--;
      end
      if (exp_push) begin
         mq[mcount] = wexp;
         mcount++;
      end
      if (!cfg_side_en) begin
         m_synced = 0; m_idle = 0;
      end else if (ss) begin
         m_synced = 1; m_idle = 0;
      end else if (sv) begin
         m_idle = 0;
      end else if (m_idle == L - 1) begin
         m_synced = 0; m_idle = 0;
      end else begin
         m_idle++;
      end
      if (!m_locked) begin
         m_locked = 1;
         m_mode = cfg_side_sel;
      end
      @(negedge clk);
   endtask

   task automatic do_reset(input logic sel);
      rst_n = 0; cfg_side_sel = sel;
      pipe_n = 0; sb_valid = 1; sb_sync = 0; q_pop = 1;
      model_reset();
      repeat (2) @(negedge clk);
      #5;
      chk("R9", "push_o", int'(push_o), 0);
      chk("R9", "q_count", int'(q_count), 0);
      chk("R9", "q_empty", int'(q_empty), 1);
      chk("R9", "proto_err", int'(proto_err), 0);
      chk("R9", "ovf_err", int'(ovf_err), 0);
      @(negedge clk);
      rst_n = 1;
   endtask

   task automatic drain(input string tag);
      for (int i = 0; i < D + 1; i++) cyc(tag, 1'b1, '0, 1'b0, '0, 1'b0, 1'b1);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // ---------- pipelined route ----------
      cfg_side_en = 1'b0;
      do_reset(1'b0);
      cyc("R1", 1'b0, 8'hA5, 1'b0, '0, 1'b0, 1'b0);   // not yet locked: dropped
      cfg_side_sel = 1'b1;                            // late change ignored
      cyc("R1", 1'b0, 8'h11, 1'b0, '0, 1'b0, 1'b0);   // still pipelined
      drain("R8");
      for (int p = 0; p < 16; p++) begin
         for (int i = 0; i < 4; i++) begin
            logic pn;
            pn = !p[i];
            cyc(pn ? "R3" : "R2", pn, W'(p * 4 + i), 1'b0, '0, 1'b0, i[0]);
         end
      end
      drain("R8");
      cyc("R6", 1'b1, '0, 1'b1, 8'h33, 1'b0, 1'b0);  // sideband disabled: no error
      cfg_side_en = 1'b1;
      cyc("R6", 1'b1, '0, 1'b1, 8'h34, 1'b1, 1'b0);  // wrong route: error
      cyc("R6", 1'b1, '0, 1'b0, '0, 1'b0, 1'b0);
      cyc("R2", 1'b0, 8'h55, 1'b0, '0, 1'b0, 1'b0);
      drain("R8");

      // ---------- sideband route ----------
      cfg_side_en = 1'b1;
      do_reset(1'b1);
      cyc("R1", 1'b1, '0, 1'b0, '0, 1'b0, 1'b0);
      cfg_side_sel = 1'b0;
      cyc("R5", 1'b1, '0, 1'b1, 8'h71, 1'b0, 1'b0);  // before any sync: dropped
      cyc("R5", 1'b1, '0, 1'b0, '0, 1'b1, 1'b0);     // sync cycle
      cyc("R4", 1'b1, '0, 1'b1, 8'h72, 1'b0, 1'b0);
      for (int k = 0; k < 7; k++) begin
         cyc("R5", 1'b1, '0, 1'b0, '0, 1'b1, 1'b1);
         for (int j = 0; j < k; j++) cyc("R5", 1'b1, '0, 1'b0, '0, 1'b0, 1'b1);
         cyc("R5", 1'b1, '0, 1'b1, W'(8'h80 + k), 1'b0, 1'b1);
      end
      drain("R8");
      cyc("R5", 1'b1, '0, 1'b0, '0, 1'b1, 1'b0);
      cfg_side_en = 1'b0;
      cyc("R4", 1'b1, '0, 1'b1, 8'h90, 1'b0, 1'b0);  // disabled: ignored
      cfg_side_en = 1'b1;
      cyc("R5", 1'b1, '0, 1'b1, 8'h91, 1'b0, 1'b0);  // sync lost by disable
      cyc("R5", 1'b1, '0, 1'b0, '0, 1'b1, 1'b0);
      for (int i = 0; i < D + 2; i++)
         cyc("R7", 1'b1, '0, 1'b1, W'(8'hC0 + i), 1'b0, 1'b0);
      cyc("R6", 1'b0, 8'hEE, 1'b0, '0, 1'b0, 1'b0);  // pipelined strobe on sideband route
      cyc("R6", 1'b1, '0, 1'b0, '0, 1'b0, 1'b0);
      drain("R8");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule